// File: doc/BRIEF.md
# Successive-Approximation Controller for a Dividing DAC

This block runs the digital half of a successive-approximation converter whose DAC divides rather than multiplies. The external DAC produces an output proportional to the pixel current divided by the code `D`. A comparator reports whether that output is still above a fixed reference. The controller searches the code bits from the most significant bit down to the least significant bit. It returns the code that brings the divided output closest to the reference, and that code is a linear measure of the pixel current.

A larger code lowers the DAC output, so the per-bit decision is the reverse of a conventional SAR. When the comparator says the output is still above the reference, the code is too small, and the trial bit stays set. Each bit uses two clocks. The first clock lets the analog path settle after the code change. In the second clock the comparator is sampled and the bit is decided. An N-bit conversion therefore takes 2·N clocks. That is short enough for a 1 MHz pixel rate from a modest conversion clock.

Top module: `sar_ddac_ctrl`

## Requirements
- R1: While reset is held and after it is released, `done` is 0, `result` is 0 and `dac_code` is 0.
- R2: When `start` is sampled high while the controller is idle, the clock that follows shows `dac_code` with only bit CODE_W-1 set.
- R3: For each trial bit, `cmp_above`=1 (DAC output above the reference) keeps the bit at 1, and `cmp_above`=0 clears it. If the bit is not bit 0, the next lower bit is set as the new trial. The final code is the largest D in 0..2^CODE_W-1 for which the comparator still reports the output above the reference, or 0 if there is no such D.
- R4: Each trial code is held for one settle clock, during which `cmp_above` is ignored. The comparator is sampled only in the clock after that.
- R5: `done` goes high exactly 2·CODE_W clock edges after the edge at which `start` was accepted.
- R6: `done` is high for exactly one clock, with `result` equal to the final code. `result` keeps that value until the next `done`, and while idle `dac_code` also holds the final code.
- R7: A `start` pulse during a conversion has no effect on that conversion's timing or result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a conversion (accepted only when idle) |
| cmp_above | input | 1 | Comparator: 1 when the DAC output is above the reference |
| dac_code | output | CODE_W | Code applied to the dividing DAC |
| done | output | 1 | One-clock pulse when the result is valid |
| result | output | CODE_W | Converted pixel value |

## Verification
The bench builds the controller with CODE_W = 6. At that width the bench can sweep every pixel level that gives each of the 64 codes, including the zero code and levels above full scale that clamp to the top code. The comparator is modelled as D·3 < level, so the expected code follows from (level−1)/3, clamped to the code range.

The model drives the inverted answer in every clock in which the code has just changed. A controller that sampled during the settle clock would therefore fail. One conversion also receives a stray start pulse partway through, to show that the pulse is ignored.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_DECIDE = 2'd2
  } sar_state_t;
endpackage

// File: rtl/sar_seq.sv
module sar_seq #(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              accept,
  output logic              settle,
  output logic              decide_ev,
  output logic              last_ev,
  output logic [CODE_W-1:0] trial_mask
);
  import sar_pkg::*;
  localparam int IDX_W = (CODE_W > 1) ? $clog2(CODE_W) : 1;
  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(CODE_W - 1);

  function automatic logic [CODE_W-1:0] mask_of(input logic [IDX_W-1:0] i);
    logic [CODE_W-1:0] m;
    m = '0;
    m[i] = 1'b1;
    return m;
  endfunction

  sar_state_t       st;
  logic [IDX_W-1:0] idx;

  assign accept     = start && (st == ST_IDLE);
  assign settle     = (st == ST_SETTLE);
  assign decide_ev  = (st == ST_DECIDE);
  assign last_ev    = decide_ev && (idx == '0);
  assign trial_mask = mask_of(idx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= ST_IDLE;
      idx <= '0;
    end else begin
      case (st)
        ST_IDLE: if (accept) begin
          st  <= ST_SETTLE;
          idx <= TOP_IDX;
        end
        ST_SETTLE: st <= ST_DECIDE;
        ST_DECIDE: if (idx == '0) begin
          st <= ST_IDLE;
        end else begin
          idx <= idx - 1'b1;
          st  <= ST_SETTLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sar_code_reg.sv
module sar_code_reg #(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              decide_ev,
  input  logic              last_ev,
  input  logic              cmp_above,
  input  logic [CODE_W-1:0] trial_mask,
  output logic [CODE_W-1:0] code,
  output logic [CODE_W-1:0] resolved
);
  localparam logic [CODE_W-1:0] MSB_ONLY = {1'b1, {(CODE_W-1){1'b0}}};

  // Output above reference means D is still too small: keep the trial bit.
  function automatic logic [CODE_W-1:0] decide_bit(
    input logic [CODE_W-1:0] c, input logic [CODE_W-1:0] m, input logic above);
    return above ? c : (c & ~m);
  endfunction

  function automatic logic [CODE_W-1:0] next_trial(
    input logic [CODE_W-1:0] c, input logic [CODE_W-1:0] m, input logic fin);
    return fin ? c : (c | (m >> 1));
  endfunction

  assign resolved = decide_bit(code, trial_mask, cmp_above);

  always_ff @(posedge clk) begin
    if (!rst_n)          code <= '0;
    else if (accept)     code <= MSB_ONLY;
    else if (decide_ev)  code <= next_trial(resolved, trial_mask, last_ev);
  end
endmodule

// File: rtl/sar_out.sv
module sar_out #(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              last_ev,
  input  logic [CODE_W-1:0] resolved,
  output logic              done,
  output logic [CODE_W-1:0] result
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done   <= 1'b0;
      result <= '0;
    end else begin
      done <= last_ev;
      if (last_ev) result <= resolved;
    end
  end
endmodule

// File: rtl/sar_ddac_ctrl.sv
module sar_ddac_ctrl #(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              cmp_above,
  output logic [CODE_W-1:0] dac_code,
  output logic              done,
  output logic [CODE_W-1:0] result
);
  logic              accept;
  logic              settle;
  logic              decide_ev;
  logic              last_ev;
  logic [CODE_W-1:0] trial_mask;
  logic [CODE_W-1:0] resolved;

  sar_seq #(.CODE_W(CODE_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .accept(accept),
    .settle(settle), .decide_ev(decide_ev), .last_ev(last_ev),
    .trial_mask(trial_mask)
  );

  sar_code_reg #(.CODE_W(CODE_W)) u_code (
    .clk(clk), .rst_n(rst_n), .accept(accept), .decide_ev(decide_ev),
    .last_ev(last_ev), .cmp_above(cmp_above), .trial_mask(trial_mask),
    .code(dac_code), .resolved(resolved)
  );

  sar_out #(.CODE_W(CODE_W)) u_out (
    .clk(clk), .rst_n(rst_n), .last_ev(last_ev), .resolved(resolved),
    .done(done), .result(result)
  );
endmodule

// File: rtl/sar_ddac_chk.sv
module sar_ddac_chk #(
  parameter int CODE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              accept,
  input logic              settle,
  input logic              decide_ev,
  input logic              cmp_above,
  input logic [CODE_W-1:0] trial_mask,
  input logic [CODE_W-1:0] dac_code,
  input logic              done,
  input logic [CODE_W-1:0] result
);
  localparam int LAT = 2 * CODE_W + 1;
  localparam int CW  = $clog2(LAT + 2) + 1;
  localparam logic [CODE_W-1:0] MSB_ONLY = {1'b1, {(CODE_W-1){1'b0}}};

  logic [CW-1:0] since;
  always_ff @(posedge clk) begin
    if (!rst_n)                  since <= '0;
    else if (accept)             since <= CW'(1);
    else if (since != '0 && since != '1) since <= since + 1'b1;
  end

  p_reset_quiet_r1: assert property (@(posedge clk) !rst_n |=> (!done && result == '0 && dac_code == '0));
  p_first_trial_r2: assert property (@(posedge clk) disable iff (!rst_n) accept |=> dac_code == MSB_ONLY);
  p_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (decide_ev && cmp_above) |=> (dac_code & $past(trial_mask)) != '0);
  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (decide_ev && !cmp_above) |=> (dac_code & $past(trial_mask)) == '0);
  p_settle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n) settle |=> $stable(dac_code));
  p_latency_r5: assert property (@(posedge clk) disable iff (!rst_n) done |-> since == CW'(LAT));
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  p_done_match_r6: assert property (@(posedge clk) disable iff (!rst_n) done |-> result == dac_code);
  p_result_hold_r6: assert property (@(posedge clk) disable iff (!rst_n) !done |-> $stable(result));
endmodule

bind sar_ddac_ctrl sar_ddac_chk #(.CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .accept(accept), .settle(settle),
  .decide_ev(decide_ev), .cmp_above(cmp_above), .trial_mask(trial_mask),
  .dac_code(dac_code), .done(done), .result(result)
);

// File: tb/sim_sar_ddac_ctrl.sv
`timescale 1ns/1ps
module sim_sar_ddac_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int W = 6;
  localparam int VREF = 3;
  localparam int MAXC = (1 << W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic cmp_above;
  logic [W-1:0] dac_code, result, prev_code;
  logic done;
  int level = 0;
  int n_cmp = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // Comparator model: output above reference when D*VREF < level.
  // In the clock right after a code change the answer is inverted (unsettled).
  always @(posedge clk) prev_code <= dac_code;
  logic ideal;
  assign ideal = (int'(dac_code) * VREF) < level;
  assign cmp_above = (dac_code !== prev_code) ? ~ideal : ideal;

  sar_ddac_ctrl #(.CODE_W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .cmp_above(cmp_above),
    .dac_code(dac_code), .done(done), .result(result)
  );

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d (level=%0d)", req, act, exp, level);
    end
  endtask

  function automatic int expect_code(input int lv);
    int d;
    if (lv <= 0) return 0;
    d = (lv - 1) / VREF;
    return (d > MAXC) ? MAXC : d;
  endfunction

  task automatic convert(input int lv, input bit stray);
    int n;
    level = lv;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R2 first trial code", int'(dac_code), 1 << (W - 1));
    n = 0;
    while (n < 4 * W) begin
      @(negedge clk);
      n++;
      if (stray && n == 3) start = 1'b1;
      if (stray && n == 4) start = 1'b0;
      if (done) break;
    end
    check(stray ? "R7 latency with stray start" : "R5 latency", n, 2 * W);
    check(stray ? "R7 result with stray start" : "R3 result", int'(result), expect_code(lv));
    @(negedge clk);
    check("R6 done one clock", int'(done), 0);
    check("R6 result held", int'(result), expect_code(lv));
    check("R6 idle code holds result", int'(dac_code), expect_code(lv));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 done in reset", int'(done), 0);
    check("R1 result in reset", int'(result), 0);
    check("R1 code in reset", int'(dac_code), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle after reset", int'(done), 0);
    for (int lv = 0; lv <= (MAXC + 2) * VREF; lv++) convert(lv, 1'b0);
    convert(100, 1'b1);
    convert(1, 1'b1);
    // R4: settle-cycle comparator inversion is always active; extremes recheck it.
    convert(MAXC * VREF + 1, 1'b0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule